// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block records memory error events reported by an external ECC checker. Each event arrives as a one-cycle strobe carrying a severity flag (single-bit or multi-bit), the full physical address of the failing access and the memory row that address decodes to. The logger keeps separate sticky flags for the two severities. It holds the 4 KB page of the failing address and the row of the first error of each kind since software last cleared the matching flag. It can also signal a system error to the rest of the chip.

Software reaches the logger through a small word-addressed register port with a combinational read path and single-cycle writes. Word 0 is the error address register, word 1 the error status register and word 2 the error command register; word 3 reads zero. Flags are cleared by writing one to them. A 2-bit integrity mode input gates capture for the whole block.

The event input carries no ready signal and applies no back-pressure. Every strobe is judged in the cycle it arrives, because a memory read cannot wait for the logger. Events the logger does not keep are dropped on purpose, not queued.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous active-high reset, all three registers read zero and `sys_err` is low.
- R2: The integrity mode encoding is 00 off, 01 detect only, 10 correcting, 11 correcting with scrub. In mode 00 a strobe changes no register. In the other three modes strobes are logged.
- R3: Error address register (word 0) returns error address bits 31:12 in bits 31:12, zero in bits 11:2, the single-bit flag in bit 0 and the multi-bit flag in bit 1.
- R4: While either address-register flag is set, a further single-bit error leaves the stored page unchanged.
- R5: A multi-bit error loads the page when the multi-bit address flag is clear, even if a single-bit error is held. It never loads when the multi-bit flag is already set.
- R6: In word 0, writing 1 to bit 0 or bit 1 clears that flag and writing 0 leaves it unchanged. The page field ignores writes.
- R7: Error status register (word 1, 16 bits) holds the single-bit flag at bit 0, the first single-bit row at bits 3:1, the multi-bit flag at bit 4 and the first multi-bit row at bits 7:5. Each row field loads only when its flag goes from 0 to 1, and it keeps its value while the flag is clear.
- R8: In word 1, writing 1 to bit 0 or bit 4 clears that flag, writing 0 leaves it unchanged, and the row fields ignore writes.
- R9: Error command register (word 2) stores written bits 1:0: bit 0 enables system-error signalling on single-bit errors and bit 1 on multi-bit errors. Its other bits and all of word 3 read zero.
- R10: `sys_err` pulses high for one cycle, in the cycle after a strobe, when that strobe sets a status flag that was clear and the matching command enable is set.
- R11: When a strobe and a clearing write to the same flag fall in one cycle, the flag ends set. Row and page loading are then judged on the flag values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle error event strobe |
| err_multi | input | 1 | 1 = multi-bit error, 0 = single-bit |
| err_addr | input | 32 | Physical address of the failing access |
| err_row | input | 3 | Row decoded from the failing address |
| integ_mode | input | 2 | Integrity mode (00 off, 01 detect, 10 correct, 11 correct+scrub) |
| reg_addr | input | 2 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sys_err | output | 1 | System-error pulse |

## Verification
The assertions check on every cycle the properties that depend only on local state. A held multi-bit page never moves, and a held single-bit page moves only for a multi-bit error. A row field is stable while its flag stays set, and a strobe always leaves its flag set. Nothing is logged in mode 00, every `sys_err` pulse follows an accepted strobe, and the command register changes only on a write to it. The bench scenarios are needed to show what those properties cannot. Those scenarios cover the exact read-back layout of each word and the choice of which address wins between competing events. They also show that rows are kept across a clear and reloaded only on the next first error. Finally, they check that a pulse needs both a new flag and an enabled severity, and the outcome when a clear collides with an event.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

  typedef enum logic [1:0] {
    INTEG_OFF     = 2'b00,
    INTEG_DETECT  = 2'b01,
    INTEG_CORRECT = 2'b10,
    INTEG_SCRUB   = 2'b11
  } integ_mode_e;

  // register word indices
  localparam int unsigned WORD_ERRADDR = 0;
  localparam int unsigned WORD_STATUS  = 1;
  localparam int unsigned WORD_CMD     = 2;

  // severity slots
  localparam int unsigned KIND_SINGLE = 0;
  localparam int unsigned KIND_MULTI  = 1;
  localparam int unsigned NUM_KINDS   = 2;

  localparam int unsigned STATUS_W = 16;
  localparam int unsigned CMD_W    = 8;

endpackage

// File: rtl/ecc_evt_qual.sv
module ecc_evt_qual
  import ecc_log_pkg::*;
(
  input  logic       err_valid,
  input  logic       err_multi,
  input  logic [1:0] integ_mode,
  output logic       take_single,
  output logic       take_multi
);

  logic accept;

  always_comb begin
    accept      = err_valid && (integ_mode_e'(integ_mode) != INTEG_OFF);
    take_single = accept && !err_multi;
    take_multi  = accept && err_multi;
  end

endmodule

// File: rtl/ecc_addr_latch.sv
module ecc_addr_latch #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  localparam int unsigned PAGE_W  = ADDR_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_single,
  input  logic              take_multi,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              clr_single,
  input  logic              clr_multi,
  output logic [PAGE_W-1:0] page_q,
  output logic              sbe_q,
  output logic              mbe_q
);

  logic load_page;
  logic unused_low_addr;

  assign unused_low_addr = ^addr_in[PAGE_LSB-1:0];

  always_comb begin
    load_page = (take_multi && !mbe_q) ||
                (take_single && !sbe_q && !mbe_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
    end else begin
      if (load_page)
        page_q <= addr_in[ADDR_W-1:PAGE_LSB];
      sbe_q <= take_single || (sbe_q && !clr_single);
      mbe_q <= take_multi  || (mbe_q && !clr_multi);
    end
  end

  AST_MB_PAGE_LOCK: assert property (@(posedge clk) disable iff (rst)
    ($past(mbe_q) && mbe_q) |-> $stable(page_q)); // R5

  AST_SB_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(sbe_q) && sbe_q && !$past(take_multi)) |-> $stable(page_q)); // R4

endmodule

// File: rtl/ecc_kind_log.sv
module ecc_kind_log #(
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [ROW_W-1:0] row_in,
  input  logic             clr,
  output logic             flag_q,
  output logic [ROW_W-1:0] row_q,
  output logic             first_hit
);

  always_comb first_hit = take && !flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (first_hit)
        row_q <= row_in;
      flag_q <= take || (flag_q && !clr);
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_q) && flag_q) |-> $stable(row_q)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(take)) |-> flag_q); // R11

endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned RA_W     = 2,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned PAGE_W  = ADDR_W - PAGE_LSB,
  localparam int unsigned MEF_BIT = ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PAGE_W-1:0] page_q,
  input  logic              asbe_q,
  input  logic              ambe_q,
  input  logic              sef_q,
  input  logic [ROW_W-1:0]  srow_q,
  input  logic              mef_q,
  input  logic [ROW_W-1:0]  mrow_q,
  output logic              clr_asbe,
  output logic              clr_ambe,
  output logic              clr_sef,
  output logic              clr_mef,
  output logic [1:0]        cmd_q,
  output logic [DATA_W-1:0] reg_rdata
);

  logic                wr_addr_word, wr_stat_word, wr_cmd_word;
  logic [ADDR_W-1:0]   addr_word;
  logic [STATUS_W-1:0] stat_word;
  logic [CMD_W-1:0]    cmd_word;
  logic                unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_comb begin
    wr_addr_word = reg_we && (reg_addr == RA_W'(WORD_ERRADDR));
    wr_stat_word = reg_we && (reg_addr == RA_W'(WORD_STATUS));
    wr_cmd_word  = reg_we && (reg_addr == RA_W'(WORD_CMD));
    clr_asbe = wr_addr_word && reg_wdata[0];
    clr_ambe = wr_addr_word && reg_wdata[1];
    clr_sef  = wr_stat_word && reg_wdata[0];
    clr_mef  = wr_stat_word && reg_wdata[MEF_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cmd_q <= '0;
    else if (wr_cmd_word)
      cmd_q <= reg_wdata[1:0];
  end

  always_comb begin
    addr_word = {page_q, {(PAGE_LSB-2){1'b0}}, ambe_q, asbe_q};
    stat_word = STATUS_W'({mrow_q, mef_q, srow_q, sef_q});
    cmd_word  = CMD_W'(cmd_q);
    case (reg_addr)
      RA_W'(WORD_ERRADDR): reg_rdata = DATA_W'(addr_word);
      RA_W'(WORD_STATUS):  reg_rdata = DATA_W'(stat_word);
      RA_W'(WORD_CMD):     reg_rdata = DATA_W'(cmd_word);
      default:             reg_rdata = '0;
    endcase
  end

  AST_CMD_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(wr_cmd_word)) |-> $stable(cmd_q)); // R9

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned PAGE_LSB = 12,
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned RA_W     = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic              err_multi,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [ROW_W-1:0]  err_row,
  input  logic [1:0]        integ_mode,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_err
);

  localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;

  logic                 take_single, take_multi;
  logic [PAGE_W-1:0]    page_q;
  logic                 asbe_q, ambe_q;
  logic                 clr_asbe, clr_ambe, clr_sef, clr_mef;
  logic [1:0]           cmd_q;
  logic [NUM_KINDS-1:0] take_k, clr_k, flag_k, first_k;
  logic [ROW_W-1:0]     row_k [NUM_KINDS];

  ecc_evt_qual u_qual (
    .err_valid   (err_valid),
    .err_multi   (err_multi),
    .integ_mode  (integ_mode),
    .take_single (take_single),
    .take_multi  (take_multi)
  );

  ecc_addr_latch #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .take_single (take_single),
    .take_multi  (take_multi),
    .addr_in     (err_addr),
    .clr_single  (clr_asbe),
    .clr_multi   (clr_ambe),
    .page_q      (page_q),
    .sbe_q       (asbe_q),
    .mbe_q       (ambe_q)
  );

  assign take_k[KIND_SINGLE] = take_single;
  assign take_k[KIND_MULTI]  = take_multi;
  assign clr_k[KIND_SINGLE]  = clr_sef;
  assign clr_k[KIND_MULTI]   = clr_mef;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    ecc_kind_log #(.ROW_W(ROW_W)) u_kind (
      .clk       (clk),
      .rst       (rst),
      .take      (take_k[k]),
      .row_in    (err_row),
      .clr       (clr_k[k]),
      .flag_q    (flag_k[k]),
      .row_q     (row_k[k]),
      .first_hit (first_k[k])
    );
  end

  ecc_reg_port #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .ROW_W(ROW_W),
    .RA_W(RA_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .page_q    (page_q),
    .asbe_q    (asbe_q),
    .ambe_q    (ambe_q),
    .sef_q     (flag_k[KIND_SINGLE]),
    .srow_q    (row_k[KIND_SINGLE]),
    .mef_q     (flag_k[KIND_MULTI]),
    .mrow_q    (row_k[KIND_MULTI]),
    .clr_asbe  (clr_asbe),
    .clr_ambe  (clr_ambe),
    .clr_sef   (clr_sef),
    .clr_mef   (clr_mef),
    .cmd_q     (cmd_q),
    .reg_rdata (reg_rdata)
  );

  // pulse on a first error of an enabled severity
  always_ff @(posedge clk) begin
    if (rst)
      sys_err <= 1'b0;
    else
      sys_err <= |(first_k & cmd_q);
  end

  AST_SERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    sys_err |-> ($past(err_valid) && ($past(integ_mode) != 2'b00))); // R10

  AST_OFF_NO_LOG: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(integ_mode) == 2'b00) && ($past(flag_k) == '0)
     && !$past(asbe_q) && !$past(ambe_q))
    |-> ((flag_k == '0) && !asbe_q && !ambe_q)); // R2

endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 1'b0;
  logic        err_multi = 1'b0;
  logic [31:0] err_addr = '0;
  logic [2:0]  err_row = '0;
  logic [1:0]  integ_mode = 2'b10;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_err;

  integer checks = 0;
  integer failures = 0;
  bit     done = 1'b0;

  always #4 clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_multi(err_multi),
    .err_addr(err_addr), .err_row(err_row), .integ_mode(integ_mode),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_err(sys_err)
  );

  // behavioural reference state
  bit [19:0] m_page;
  bit        m_asbe, m_ambe, m_sef, m_mef, m_serr;
  bit [2:0]  m_srow, m_mrow;
  bit [1:0]  m_cmd;

  function automatic bit [31:0] model_read(input bit [1:0] a);
    case (a)
      2'd0: return {m_page, 10'd0, m_ambe, m_asbe};
      2'd1: return {24'd0, m_mrow, m_mef, m_srow, m_sef};
      2'd2: return {30'd0, m_cmd};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    bit acc, ts, tm, wa, ws;
    if (rst) begin
      m_page = '0; m_asbe = 0; m_ambe = 0; m_sef = 0; m_mef = 0;
      m_srow = '0; m_mrow = '0; m_cmd = '0; m_serr = 0;
    end else begin
      acc = err_valid && (integ_mode != 2'b00);
      ts = acc && !err_multi;
      tm = acc && err_multi;
      wa = reg_we && reg_addr == 2'd0;
      ws = reg_we && reg_addr == 2'd1;
      m_serr = (ts && !m_sef && m_cmd[0]) || (tm && !m_mef && m_cmd[1]);
      if ((tm && !m_ambe) || (ts && !m_asbe && !m_ambe)) m_page = err_addr[31:12];
      if (ts && !m_sef) m_srow = err_row;
      if (tm && !m_mef) m_mrow = err_row;
      m_asbe = ts || (m_asbe && !(wa && reg_wdata[0]));
      m_ambe = tm || (m_ambe && !(wa && reg_wdata[1]));
      m_sef  = ts || (m_sef && !(ws && reg_wdata[0]));
      m_mef  = tm || (m_mef && !(ws && reg_wdata[4]));
      if (reg_we && reg_addr == 2'd2) m_cmd = reg_wdata[1:0];
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    model_step();
    #2;
    if (!done) begin
      checks++;
      if (reg_rdata !== model_read(reg_addr)) begin
        failures++;
        $display("FAIL R3 model word %0d actual=%h expected=%h", reg_addr, reg_rdata, model_read(reg_addr));
      end
      checks++;
      if (sys_err !== m_serr) begin
        failures++;
        $display("FAIL R10 model sys_err actual=%b expected=%b", sys_err, m_serr);
      end
    end
  end

  task automatic chk(input bit [1:0] a, input bit [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s word %0d actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // event, optionally with a simultaneous write; sys_err checked one cycle on
  task automatic ev_full(input bit multi, input bit [31:0] a, input bit [2:0] row,
                         input bit we, input bit [1:0] wa, input bit [31:0] wd,
                         input bit exp_serr, input bit chk_serr);
    @(negedge clk);
    err_valid = 1'b1; err_multi = multi; err_addr = a; err_row = row;
    reg_we = we; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    #3;
    if (chk_serr) begin
      checks++;
      if (sys_err !== exp_serr) begin
        failures++;
        $display("FAIL R10 sys_err actual=%b expected=%b", sys_err, exp_serr);
      end
    end
    @(negedge clk);
    err_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic ev(input bit multi, input bit [31:0] a, input bit [2:0] row);
    ev_full(multi, a, row, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic ev_serr(input bit multi, input bit [31:0] a, input bit [2:0] row, input bit exp);
    ev_full(multi, a, row, 1'b0, 2'd0, 32'd0, exp, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(2'd0, 32'h0, "R1");
    chk(2'd1, 32'h0, "R1");
    chk(2'd2, 32'h0, "R1");
    // R2 mode 00 logs nothing
    integ_mode = 2'b00;
    ev(1'b0, 32'h1234_5678, 3'd5);
    ev(1'b1, 32'h1234_5678, 3'd5);
    chk(2'd0, 32'h0, "R2");
    chk(2'd1, 32'h0, "R2");
    integ_mode = 2'b10;
    // R3 address layout, R7 status layout
    ev(1'b0, 32'hABCD_E7FF, 3'd3);
    chk(2'd0, 32'hABCD_E001, "R3");
    chk(2'd1, 32'h0000_0007, "R7");
    // R4 second single-bit error keeps the first page and row
    ev(1'b0, 32'h1111_1000, 3'd6);
    chk(2'd0, 32'hABCD_E001, "R4");
    chk(2'd1, 32'h0000_0007, "R4");
    // R5 multi-bit overrides a held single-bit page
    ev(1'b1, 32'h2222_2FFF, 3'd4);
    chk(2'd0, 32'h2222_2003, "R5");
    chk(2'd1, 32'h0000_0097, "R7");
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h1);
    chk(2'd0, 32'h2222_2002, "R6");
    ev(1'b0, 32'h3333_3000, 3'd1);
    chk(2'd0, 32'h2222_2003, "R5");
    chk(2'd1, 32'h0000_0093, "R7");
    ev(1'b1, 32'h4444_4000, 3'd7);
    chk(2'd0, 32'h2222_2003, "R5");
    chk(2'd1, 32'h0000_0093, "R7");
    // R6 zeros in flag bits and writes to the page field have no effect
    wr(2'd0, 32'hFFFF_FFFC);
    chk(2'd0, 32'h2222_2003, "R6");
    wr(2'd0, 32'h3);
    chk(2'd0, 32'h2222_2000, "R6");
    // R8 status write-one-to-clear, rows retained
    wr(2'd1, 32'h0000_FFEE);
    chk(2'd1, 32'h0000_0093, "R8");
    wr(2'd1, 32'h11);
    chk(2'd1, 32'h0000_0082, "R8");
    // R7 row reloads on the next first error
    ev(1'b0, 32'h5555_5123, 3'd5);
    chk(2'd1, 32'h0000_008B, "R7");
    chk(2'd0, 32'h5555_5001, "R3");
    // R9 command register
    wr(2'd2, 32'hFFFF_FFFF);
    chk(2'd2, 32'h0000_0003, "R9");
    wr(2'd3, 32'hFFFF_FFFF);
    chk(2'd3, 32'h0, "R9");
    wr(2'd2, 32'h1);
    chk(2'd2, 32'h1, "R9");
    // R10 system-error pulse rules
    wr(2'd0, 32'h3);
    wr(2'd1, 32'h11);
    chk(2'd1, 32'h0000_008A, "R8");
    ev_serr(1'b0, 32'h6000_0000, 3'd2, 1'b1);
    chk(2'd1, 32'h0000_0085, "R7");
    ev_serr(1'b0, 32'h6100_0000, 3'd3, 1'b0);
    ev_serr(1'b1, 32'h6200_0000, 3'd1, 1'b0);
    chk(2'd1, 32'h0000_0035, "R7");
    wr(2'd1, 32'h10);
    chk(2'd1, 32'h0000_0025, "R8");
    wr(2'd2, 32'h2);
    ev_serr(1'b1, 32'h6300_0000, 3'd6, 1'b1);
    chk(2'd1, 32'h0000_00D5, "R10");
    // R11 clear and event in the same cycle
    ev_full(1'b0, 32'h6400_0000, 3'd7, 1'b1, 2'd1, 32'h1, 1'b0, 1'b1);
    chk(2'd1, 32'h0000_00D5, "R11");
    wr(2'd1, 32'h1);
    chk(2'd1, 32'h0000_00D4, "R11");
    // R2 modes 01 and 11 also log
    wr(2'd1, 32'h11);
    chk(2'd1, 32'h0000_00C4, "R8");
    integ_mode = 2'b01;
    ev_serr(1'b0, 32'h7000_0000, 3'd0, 1'b0);
    chk(2'd1, 32'h0000_00C1, "R2");
    integ_mode = 2'b11;
    ev_serr(1'b1, 32'h7100_0000, 3'd3, 1'b1);
    chk(2'd1, 32'h0000_0071, "R2");
    // R1 reset clears everything again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(2'd0, 32'h0, "R1");
    chk(2'd1, 32'h0, "R1");
    chk(2'd2, 32'h0, "R1");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule